// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers 32 level-sensitive interrupt sources into two active-high request lines: a normal request and a fast request. Each line has its own enable mask, and a line is asserted while any source that is pending and enabled for it is present. Software changes either mask through a pair of write addresses, one that adds bits and one that removes them, so no read-modify-write is ever needed. Source 0 can also be raised and dropped by software through two dedicated addresses, which makes it usable as a software interrupt.

The register interface is word addressed with a single select and a write flag. Writes take effect on the clock edge. Reads are combinational from the current register state. Both the raw source levels and the masked view for each line can be read. The request outputs are registered, so each one follows the level and mask registers with one cycle of delay.

Top module: `dual_lvl_intc`

## Requirements
- R1: Level bits 1 to 31 copy the corresponding input on every clock edge, so each reads 1 while its input was high at the previous edge and 0 while it was low.
- R2: On each edge, `irq_o` loads the OR of (level AND normal mask) and `fast_o` loads the OR of (level AND fast mask), both taken from the register values before that edge.
- R3: A read with `bus_sel`=1 and `bus_wr`=0 returns: word 0 the level ANDed with the normal mask; words 1 and 9 the raw level; word 2 the normal mask; word 8 the level ANDed with the fast mask; word 10 the fast mask. With `bus_sel`=0 or `bus_wr`=1, `bus_rdata` is 0.
- R4: A write to word 2 (normal) or word 10 (fast) ORs `bus_wdata` into that mask. A write to word 3 (normal) or word 11 (fast) clears the mask bits where `bus_wdata` is 1.
- R5: A write to word 4 with `bus_wdata` bit 0 = 1 sets level bit 0. A write to word 5 with bit 0 = 1 clears it. Such writes with bit 0 = 0 leave level bit 0 unchanged. A read of word 4 returns level bit 0 in bit 0 and zero in bits 31 to 1.
- R6: Apart from R5 writes, level bit 0 takes the value of `src_lvl[0]` only on an edge where `src_lvl[0]` differs from its value at the previous edge (a reset counts as a previous value of 0). When a soft write and such an input change meet on the same edge, the soft write decides the bit.
- R7: Reads of words 3, 5, 11 and of any word not listed in R3 or R5 return 0. Writes to words 0, 1, 8, 9 and to any unlisted word change no state.
- R8: While `rst_n` is low on an edge, both masks, the level register and both outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 32 | Level-sensitive interrupt sources |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Normal interrupt request, active high |
| fast_o | output | 1 | Fast interrupt request, active high |

## Verification
The bench targets the arbitration of level bit 0. It drives a soft clear while the input rises, holds the input high afterwards, and then toggles the input. A design that let the input win the shared edge would leave the bit set. A design that copied the input level every cycle would undo the soft write on the next edge. The bench also writes to status and unknown words and then reads both masks back, so any aliasing of those addresses onto a mask shows up at the read port. Mixed set and clear patterns check that the two lines really have independent masks, and output checks on every cycle catch an off-by-one in the output register stage.

// File: rtl/intc_pkg.sv
// Shared definitions for the dual-output level interrupt controller.
// Assumes a word-addressed bus of ADDR_W bits.
package intc_pkg;
    localparam int ADDR_W = 6;
    typedef logic [ADDR_W-1:0] waddr_t;

    localparam waddr_t WD_NORM_STAT = 6'd0;
    localparam waddr_t WD_RAW_A     = 6'd1;
    localparam waddr_t WD_NORM_ON   = 6'd2;
    localparam waddr_t WD_NORM_OFF  = 6'd3;
    localparam waddr_t WD_SOFT_ON   = 6'd4;
    localparam waddr_t WD_SOFT_OFF  = 6'd5;
    localparam waddr_t WD_FAST_STAT = 6'd8;
    localparam waddr_t WD_RAW_B     = 6'd9;
    localparam waddr_t WD_FAST_ON   = 6'd10;
    localparam waddr_t WD_FAST_OFF  = 6'd11;

    localparam int N_LINES = 2;   // 0 = normal, 1 = fast
endpackage

// File: rtl/intc_wr_decode.sv
// Write decoder: turns one bus write into single-cycle strobes for the
// mask banks and the software level controls. Assumes one access per cycle.
module intc_wr_decode
    import intc_pkg::*;
(
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  waddr_t               bus_addr,
    input  logic                 wbit0,
    output logic [N_LINES-1:0]   mask_add,
    output logic [N_LINES-1:0]   mask_del,
    output logic                 soft_on,
    output logic                 soft_off
);
    logic wr_act;

    // Decode the write address into strobes; unlisted words produce none.
    always_comb begin
        wr_act      = bus_sel & bus_wr;
        mask_add[0] = wr_act && (bus_addr == WD_NORM_ON);
        mask_del[0] = wr_act && (bus_addr == WD_NORM_OFF);
        mask_add[1] = wr_act && (bus_addr == WD_FAST_ON);
        mask_del[1] = wr_act && (bus_addr == WD_FAST_OFF);
        soft_on     = wr_act && (bus_addr == WD_SOFT_ON)  && wbit0;
        soft_off    = wr_act && (bus_addr == WD_SOFT_OFF) && wbit0;
    end
endmodule

// File: rtl/intc_mask_bank.sv
// One enable mask with separate bit-set and bit-clear write strobes.
// Assumes set and clear strobes are never active together.
module intc_mask_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         add_stb,
    input  logic         del_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);
    // Hold the mask; OR in on set, knock out bits on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (add_stb) mask_q <= mask_q | wdata;
        else if (del_stb) mask_q <= mask_q & ~wdata;
    end
endmodule

// File: rtl/intc_level_track.sv
// Raw level register. Bits above SOFT_BIT copy their input each edge.
// Bit SOFT_BIT is shared: a software write decides it, otherwise it only
// follows its input when that input changes. Assumes inputs are synchronous.
module intc_level_track #(
    parameter int W        = 32,
    parameter int SOFT_BIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         soft_on,
    input  logic         soft_off,
    output logic [W-1:0] lvl_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == SOFT_BIT) begin : g_shared
            logic prev_q;
            // Remember the input seen at the previous edge.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= src[i];
            end
            // Bus write wins; otherwise track input edges only.
            always_ff @(posedge clk) begin
                if (!rst_n)                lvl_q[i] <= 1'b0;
                else if (soft_on)          lvl_q[i] <= 1'b1;
                else if (soft_off)         lvl_q[i] <= 1'b0;
                else if (src[i] != prev_q) lvl_q[i] <= src[i];
            end
        end else begin : g_plain
            // Plain level capture.
            always_ff @(posedge clk) begin
                if (!rst_n) lvl_q[i] <= 1'b0;
                else        lvl_q[i] <= src[i];
            end
        end
    end
endmodule

// File: rtl/intc_out_stage.sv
// Registered request output: high when any enabled source is pending.
module intc_out_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] mask,
    output logic         req_q
);
    // Reduce the masked level into one registered request.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= |(lvl & mask);
    end
endmodule

// File: rtl/dual_lvl_intc.sv
// Top of the dual-output level interrupt controller: write decode, level
// register, one mask bank and output stage per line, and the read mux.
// Assumes N_SRC is the bus data width.
module dual_lvl_intc
    import intc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_lvl,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [5:0]        bus_addr,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              fast_o
);
    logic [N_LINES-1:0] mask_add, mask_del, req_q;
    logic               soft_on, soft_off;
    logic [N_SRC-1:0]   lvl_q;
    logic [N_SRC-1:0]   mask_q [N_LINES];
    logic [N_SRC-1:0]   nmask_q, fmask_q;

    intc_wr_decode u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wbit0    (bus_wdata[0]),
        .mask_add (mask_add),
        .mask_del (mask_del),
        .soft_on  (soft_on),
        .soft_off (soft_off)
    );

    intc_level_track #(.W(N_SRC), .SOFT_BIT(0)) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src_lvl),
        .soft_on  (soft_on),
        .soft_off (soft_off),
        .lvl_q    (lvl_q)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        intc_mask_bank #(.W(N_SRC)) u_mask (
            .clk     (clk),
            .rst_n   (rst_n),
            .add_stb (mask_add[g]),
            .del_stb (mask_del[g]),
            .wdata   (bus_wdata),
            .mask_q  (mask_q[g])
        );
        intc_out_stage #(.W(N_SRC)) u_out (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (lvl_q),
            .mask  (mask_q[g]),
            .req_q (req_q[g])
        );
    end

    assign nmask_q = mask_q[0];
    assign fmask_q = mask_q[1];
    assign irq_o   = req_q[0];
    assign fast_o  = req_q[1];

    // Read mux: current state per word, zero for everything else.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                WD_NORM_STAT: bus_rdata = lvl_q & nmask_q;
                WD_RAW_A,
                WD_RAW_B:     bus_rdata = lvl_q;
                WD_NORM_ON:   bus_rdata = nmask_q;
                WD_SOFT_ON:   bus_rdata = {{(N_SRC-1){1'b0}}, lvl_q[0]};
                WD_FAST_STAT: bus_rdata = lvl_q & fmask_q;
                WD_FAST_ON:   bus_rdata = fmask_q;
                default:      bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/intc_dual_chk.sv
// Assertion checker for dual_lvl_intc, attached by bind.
module intc_dual_chk #(
    parameter int N_SRC = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_lvl,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [5:0]       bus_addr,
    input logic [N_SRC-1:0] bus_wdata,
    input logic             irq_o,
    input logic             fast_o,
    input logic [N_SRC-1:0] lvl,
    input logic [N_SRC-1:0] nmask,
    input logic [N_SRC-1:0] fmask
);
    logic wr_now;
    assign wr_now = bus_sel & bus_wr;

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> lvl[N_SRC-1:1] == $past(src_lvl[N_SRC-1:1])); // R1
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> irq_o == |($past(lvl) & $past(nmask))); // R2
    AST_FAST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> fast_o == |($past(lvl) & $past(fmask))); // R2
    AST_NMASK_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && bus_addr == 6'd2) |=> nmask == ($past(nmask) | $past(bus_wdata))); // R4
    AST_FMASK_DEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && bus_addr == 6'd11) |=> (fmask & $past(bus_wdata)) == '0); // R4
    AST_SOFT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && bus_addr == 6'd4 && bus_wdata[0]) |=> lvl[0]); // R5
    AST_SOFT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && bus_addr == 6'd5 && bus_wdata[0]) |=> !lvl[0]); // R6
    AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && (bus_addr == 6'd0 || bus_addr == 6'd8)) |=> ($stable(nmask) && $stable(fmask))); // R7
endmodule

bind dual_lvl_intc intc_dual_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lvl   (src_lvl),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .fast_o    (fast_o),
    .lvl       (lvl_q),
    .nmask     (nmask_q),
    .fmask     (fmask_q)
);

// File: tb/test_dual_lvl_intc.sv
`timescale 1ns/1ps
module test_dual_lvl_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_lvl = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fast_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [31:0] m_lvl = '0, m_nm = '0, m_fm = '0;
    logic        m_prev = 1'b0, m_irq = 1'b0, m_fast = 1'b0;

    always #2.5 clk = ~clk;

    dual_lvl_intc i_dual_lvl_intc (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fast_o(fast_o)
    );

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (a)
            6'd0:       return m_lvl & m_nm;
            6'd1, 6'd9: return m_lvl;
            6'd2:       return m_nm;
            6'd4:       return {31'd0, m_lvl[0]};
            6'd8:       return m_lvl & m_fm;
            6'd10:      return m_fm;
            default:    return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model one edge from the inputs currently driven.
    task automatic model_edge();
        logic       wr;
        logic [31:0] nl;
        wr = bus_sel & bus_wr;
        if (!rst_n) begin
            m_lvl = '0; m_nm = '0; m_fm = '0; m_prev = 0; m_irq = 0; m_fast = 0;
            return;
        end
        m_irq  = |(m_lvl & m_nm);
        m_fast = |(m_lvl & m_fm);
        nl = {src_lvl[31:1], m_lvl[0]};
        if (wr && bus_addr == 6'd4 && bus_wdata[0])      nl[0] = 1'b1;
        else if (wr && bus_addr == 6'd5 && bus_wdata[0]) nl[0] = 1'b0;
        else if (src_lvl[0] != m_prev)                   nl[0] = src_lvl[0];
        m_prev = src_lvl[0];
        m_lvl  = nl;
        if (wr) begin
            case (bus_addr)
                6'd2:  m_nm = m_nm | bus_wdata;
                6'd3:  m_nm = m_nm & ~bus_wdata;
                6'd10: m_fm = m_fm | bus_wdata;
                6'd11: m_fm = m_fm & ~bus_wdata;
                default: ;
            endcase
        end
    endtask

    // Apply current drive for one cycle, check read data before the edge
    // and the registered outputs after it.
    task automatic step(input string tag);
        #1;
        if (bus_sel && !bus_wr) chk({tag, " R3/R7 read"}, bus_rdata, exp_read(bus_addr));
        @(posedge clk);
        model_edge();
        #1;
        chk("R2 irq_o", {31'd0, irq_o}, {31'd0, m_irq});
        chk("R2 fast_o", {31'd0, fast_o}, {31'd0, m_fast});
    endtask

    task automatic wr_op(input logic [5:0] a, input logic [31:0] d, input string tag);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        step(tag);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_op(input logic [5:0] a, input string tag);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        step(tag);
        bus_sel = 0;
    endtask

    task automatic idle();
        bus_sel = 0; bus_wr = 0;
        step("idle");
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        // Reset
        rst_n = 0;
        src_lvl = 32'hFFFF_FFFF;
        repeat (3) idle();
        rst_n = 1;
        src_lvl = '0;
        #1;
        chk("R8 irq after reset", {31'd0, irq_o}, 32'd0);
        chk("R8 fast after reset", {31'd0, fast_o}, 32'd0);
        idle();
        rd_op(6'd2, "R8 nmask");
        rd_op(6'd10, "R8 fmask");
        rd_op(6'd1, "R8 level");

        // Directed: masks, R1, R4
        src_lvl = 32'h0000_0100;
        wr_op(6'd2, 32'h0000_0300, "R4 nset");
        wr_op(6'd10, 32'h8000_0000, "R4 fset");
        idle(); idle();
        rd_op(6'd0, "R3 nstat");
        rd_op(6'd8, "R3 fstat");
        src_lvl = 32'h8000_0000;
        idle(); idle();
        rd_op(6'd9, "R1 raw");
        wr_op(6'd11, 32'hC000_0000, "R4 fclr");
        wr_op(6'd3, 32'h0000_0100, "R4 nclr");
        rd_op(6'd10, "R4 fmask");
        rd_op(6'd2, "R4 nmask");

        // R7: status and unknown writes ignored, clear words read zero
        wr_op(6'd0, 32'hFFFF_FFFF, "R7 w0");
        wr_op(6'd8, 32'hFFFF_FFFF, "R7 w8");
        wr_op(6'd1, 32'hFFFF_FFFF, "R7 w1");
        wr_op(6'd13, 32'hFFFF_FFFF, "R7 w13");
        wr_op(6'd6, 32'h0000_0001, "R7 w6");
        rd_op(6'd2, "R7 nmask kept");
        rd_op(6'd10, "R7 fmask kept");
        rd_op(6'd4, "R7 soft kept");
        rd_op(6'd3, "R7 rd3");
        rd_op(6'd11, "R7 rd11");
        rd_op(6'd63, "R7 rd63");

        // R5: soft set/clear, bit0 = 0 has no effect
        wr_op(6'd2, 32'h0000_0001, "R5 en0");
        wr_op(6'd4, 32'hFFFF_FFFE, "R5 set b0=0");
        rd_op(6'd4, "R5 unchanged");
        wr_op(6'd4, 32'h0000_0001, "R5 set");
        rd_op(6'd4, "R5 soft read");
        wr_op(6'd5, 32'hFFFF_FFFE, "R5 clr b0=0");
        rd_op(6'd4, "R5 still set");
        wr_op(6'd5, 32'h0000_0001, "R5 clr");
        rd_op(6'd4, "R5 cleared");

        // R6: conflict with input rise; bus wins, level hold ignored
        src_lvl[0] = 1'b1;
        wr_op(6'd5, 32'h0000_0001, "R6 conflict");
        rd_op(6'd4, "R6 bus wins");
        idle();
        rd_op(6'd4, "R6 held high no change");
        src_lvl[0] = 1'b0;
        idle();
        src_lvl[0] = 1'b1;
        idle();
        rd_op(6'd4, "R6 follows rise");

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [5:0] a;
            op = int'($urandom_range(0, 9));
            if ($urandom_range(0, 3) == 0) src_lvl[31:1] = 31'($urandom);
            if ($urandom_range(0, 7) == 0) src_lvl[0] = ~src_lvl[0];
            a = 6'($urandom_range(0, 15));
            if ($urandom_range(0, 15) == 0) a = 6'($urandom);
            if (op < 4)      rd_op(a, "R3 random");
            else if (op < 9) wr_op(a, ($urandom_range(0, 1) == 1) ? $urandom : ($urandom & $urandom), "R4 random");
            else             idle();
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule